// File: doc/BRIEF.md
# Page-Wrapping Effective Address Generator

This block forms the memory address for a small 8-bit processor whose 16-bit pointers are split into a 4-bit page number (bits 15:12) and a 12-bit offset (bits 11:0). Each request supplies a base pointer, a signed displacement byte, the extension register and two class flags. The block adds the displacement to the offset field only. Any carry or borrow is dropped at bit 11, so every result stays inside the 4 KB page of the base. The page bits leave the block exactly as they came in.

A displacement byte of 0x80 has a special meaning for memory references. In that case the extension register is used as the signed displacement. For jumps the same byte is simply -128. In auto-indexed mode the block also returns the new pointer value for the register file to write back. A negative step pre-decrements the pointer and addresses the new value. A zero or positive step addresses the old value and then post-increments the pointer. Results are registered and appear one clock after the request.

Top module: `page_ea_gen`

## Requirements
- R1: Bits 15:12 of `ea` and of `ptr_new` always equal bits 15:12 of the `base` given with the request.
- R2: For a request without auto-indexing, `ea[11:0]` = (`base[11:0]` + the step sign-extended to 12 bits) mod 4096. The step is `disp` read as two's complement (0x87 is -121). A base of 0x0105 with displacement 0x87 gives 0x008C, and a base of 0x0005 with displacement 0xF0 gives 0x0FF5.
- R3: When `is_jump`=0 and `disp`=0x80, the step is `ext` read as a signed byte in place of `disp`.
- R4: When `is_jump`=1, `disp`=0x80 is a step of -128 and `ext` has no effect on any output.
- R5: When `auto_idx`=1, `is_jump`=0 and the step is negative, `ptr_wr`=1 and `ptr_new` = base plus step (12-bit wrap). `ea` equals that new `ptr_new`.
- R6: When `auto_idx`=1, `is_jump`=0 and the step is zero or positive, `ptr_wr`=1 and `ea` = `base`. `ptr_new` = base plus step (12-bit wrap).
- R7: When `is_jump`=1, or when `auto_idx`=0, `ptr_wr`=0 and `ptr_new` = `base`. `auto_idx` has no effect on jumps.
- R8: Results appear on the clock edge after a cycle with `valid_in`=1, with `ea_valid`=1. After a cycle with `valid_in`=0, `ea_valid`=0 and `ea`, `ptr_wr` and `ptr_new` hold their values.
- R9: While `rst_n`=0, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Request present this cycle |
| base | input | 16 | Selected program counter or pointer value |
| disp | input | 8 | Signed displacement byte |
| ext | input | 8 | Extension register value |
| is_jump | input | 1 | 1 = jump class, 0 = memory reference class |
| auto_idx | input | 1 | Auto-indexed addressing requested |
| ea_valid | output | 1 | Registered result is new |
| ea | output | 16 | Effective address |
| ptr_wr | output | 1 | `ptr_new` must be written back |
| ptr_new | output | 16 | Updated pointer value |

## Verification
Extension substitution and the auto-index update can both act on one request. This happens on an auto-indexed memory reference whose displacement byte is 0x80. The sign of the extension register then decides between pre-decrement and post-increment. The bench provokes this by sweeping every displacement byte against extension values on both sides of zero. The sweep uses bases at the bottom and top of a page, so that both updates must also wrap. The expected address, write flag and new pointer come from integer arithmetic in the bench.

// File: rtl/ea_pkg.sv
package ea_pkg;
    typedef enum logic [1:0] {
        IDX_NONE = 2'd0,
        IDX_PRE  = 2'd1,
        IDX_POST = 2'd2
    } idx_kind_e;

    function automatic idx_kind_e pick_idx(input logic auto_idx,
                                           input logic is_jump,
                                           input logic step_neg);
        if (!auto_idx || is_jump) return IDX_NONE;
        else if (step_neg)        return IDX_PRE;
        else                      return IDX_POST;
    endfunction
endpackage

// File: rtl/ea_step_sel.sv
module ea_step_sel #(
    parameter int DISP_W = 8,
    parameter int OFS_W  = 12
) (
    input  logic [DISP_W-1:0] disp,
    input  logic [DISP_W-1:0] ext,
    input  logic              is_jump,
    output logic [OFS_W-1:0]  step,
    output logic              step_neg
);
    localparam logic [DISP_W-1:0] ESCAPE = {1'b1, {(DISP_W-1){1'b0}}};
    localparam int                PAD    = OFS_W - DISP_W;

    logic [DISP_W-1:0] raw;

    always_comb begin
        raw      = (!is_jump && disp == ESCAPE) ? ext : disp;
        step     = {{PAD{raw[DISP_W-1]}}, raw};
        step_neg = raw[DISP_W-1];
    end
endmodule

// File: rtl/ea_page_add.sv
module ea_page_add #(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 12
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFS_W-1:0]  step,
    output logic [ADDR_W-1:0] sum
);
    logic [OFS_W-1:0] ofs;

    always_comb begin
        ofs = base[OFS_W-1:0] + step;
        sum = {base[ADDR_W-1:OFS_W], ofs};
    end
endmodule

// File: rtl/page_ea_gen.sv
module page_ea_gen
    import ea_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 12,
    parameter int DISP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_in,
    input  logic [ADDR_W-1:0] base,
    input  logic [DISP_W-1:0] disp,
    input  logic [DISP_W-1:0] ext,
    input  logic              is_jump,
    input  logic              auto_idx,
    output logic              ea_valid,
    output logic [ADDR_W-1:0] ea,
    output logic              ptr_wr,
    output logic [ADDR_W-1:0] ptr_new
);
    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] ea;
        logic              wr;
        logic [ADDR_W-1:0] ptr;
    } res_t;

    res_t             res_d, res_q;
    logic [OFS_W-1:0] step;
    logic             step_neg;
    logic [ADDR_W-1:0] moved;
    idx_kind_e        kind;

    ea_step_sel #(.DISP_W(DISP_W), .OFS_W(OFS_W)) u_sel (
        .disp     (disp),
        .ext      (ext),
        .is_jump  (is_jump),
        .step     (step),
        .step_neg (step_neg)
    );

    ea_page_add #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_add (
        .base (base),
        .step (step),
        .sum  (moved)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = 1'b0;
        kind      = pick_idx(auto_idx, is_jump, step_neg);
        if (valid_in) begin
            res_d.vld = 1'b1;
            unique case (kind)
                IDX_PRE: begin
                    res_d.ea  = moved;
                    res_d.wr  = 1'b1;
                    res_d.ptr = moved;
                end
                IDX_POST: begin
                    res_d.ea  = base;
                    res_d.wr  = 1'b1;
                    res_d.ptr = moved;
                end
                default: begin
                    res_d.ea  = moved;
                    res_d.wr  = 1'b0;
                    res_d.ptr = base;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign ea_valid = res_q.vld;
    assign ea       = res_q.ea;
    assign ptr_wr   = res_q.wr;
    assign ptr_new  = res_q.ptr;
endmodule

// File: rtl/page_ea_gen_chk.sv
module page_ea_gen_chk #(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 12,
    parameter int DISP_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_in,
    input logic [ADDR_W-1:0] base,
    input logic [DISP_W-1:0] disp,
    input logic [DISP_W-1:0] ext,
    input logic              is_jump,
    input logic              auto_idx,
    input logic              ea_valid,
    input logic [ADDR_W-1:0] ea,
    input logic              ptr_wr,
    input logic [ADDR_W-1:0] ptr_new
);
    localparam logic [DISP_W-1:0] ESCAPE = {1'b1, {(DISP_W-1){1'b0}}};
    localparam int                PAD    = OFS_W - DISP_W;

    // R1
    a_r1_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> (ea[ADDR_W-1:OFS_W] == $past(base[ADDR_W-1:OFS_W]) &&
                      ptr_new[ADDR_W-1:OFS_W] == $past(base[ADDR_W-1:OFS_W])));

    // R3
    a_r3_ext_step: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && !is_jump && !auto_idx && disp == ESCAPE) |=>
        (ea[OFS_W-1:0] == $past(base[OFS_W-1:0]) +
                          {{PAD{$past(ext[DISP_W-1])}}, $past(ext)}));

    // R4
    a_r4_jump_literal: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && is_jump && disp == ESCAPE) |=>
        (ea[OFS_W-1:0] == $past(base[OFS_W-1:0]) + {{(PAD+1){1'b1}}, {(DISP_W-1){1'b0}}}));

    // R5
    a_r5_pre_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && auto_idx && !is_jump && disp[DISP_W-1] && disp != ESCAPE) |=>
        (ptr_wr && ea == ptr_new));

    // R6
    a_r6_post_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && auto_idx && !is_jump && !disp[DISP_W-1]) |=>
        (ptr_wr && ea == $past(base)));

    // R7
    a_r7_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && (is_jump || !auto_idx)) |=> (!ptr_wr && ptr_new == $past(base)));

    // R8
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> (!ea_valid && $stable(ea) && $stable(ptr_new) && $stable(ptr_wr)));
endmodule

bind page_ea_gen page_ea_gen_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .DISP_W(DISP_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_in (valid_in),
    .base     (base),
    .disp     (disp),
    .ext      (ext),
    .is_jump  (is_jump),
    .auto_idx (auto_idx),
    .ea_valid (ea_valid),
    .ea       (ea),
    .ptr_wr   (ptr_wr),
    .ptr_new  (ptr_new)
);

// File: tb/page_ea_gen_test.sv
`timescale 1ns/1ps
module page_ea_gen_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [15:0] base = '0;
    logic [7:0]  disp = '0;
    logic [7:0]  ext = '0;
    logic        is_jump = 1'b0;
    logic        auto_idx = 1'b0;
    logic        ea_valid;
    logic [15:0] ea;
    logic        ptr_wr;
    logic [15:0] ptr_new;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    page_ea_gen uut (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .base(base), .disp(disp),
        .ext(ext), .is_jump(is_jump), .auto_idx(auto_idx), .ea_valid(ea_valid),
        .ea(ea), .ptr_wr(ptr_wr), .ptr_new(ptr_new)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] wrap_add(input logic [15:0] b, input int step);
        int o;
        o = (int'(b[11:0]) + step + 4096) % 4096;
        return {b[15:12], 12'(o)};
    endfunction

    // one request; outputs checked one cycle later, away from the edge
    task automatic run_op(input logic [15:0] b, input logic [7:0] d, input logic [7:0] x,
                          input logic j, input logic a, input string req);
        int          step;
        logic [15:0] mv, e_ea, e_ptr;
        logic        e_wr;
        base = b; disp = d; ext = x; is_jump = j; auto_idx = a; valid_in = 1'b1;
        if (!j && d == 8'h80) step = x[7] ? int'(x) - 256 : int'(x); // R3
        else                  step = d[7] ? int'(d) - 256 : int'(d); // R2, R4
        mv = wrap_add(b, step);
        if (a && !j) begin
            e_wr  = 1'b1;
            e_ptr = mv;
            e_ea  = (step < 0) ? mv : b;   // R5 / R6
        end else begin
            e_wr  = 1'b0;                  // R7
            e_ptr = b;
            e_ea  = mv;
        end
        @(posedge clk);
        #1;
        check(req, "ea", ea, e_ea);
        check(req, "ptr_new", ptr_new, e_ptr);
        check(req, "ptr_wr", {15'd0, ptr_wr}, {15'd0, e_wr});
        check("R8", "ea_valid", {15'd0, ea_valid}, 16'd1);
        check("R1", "page", {12'd0, ea[15:12]}, {12'd0, b[15:12]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] bases [6];
        logic [7:0]  exts [3];
        logic [15:0] hold_ea, hold_ptr;
        bases = '{16'h0000, 16'h0005, 16'h0105, 16'h1FFF, 16'hF800, 16'h7FF0};
        exts  = '{8'h7F, 8'h80, 8'hC5};

        repeat (3) @(posedge clk);
        #1;
        check("R9", "ea reset", ea, 16'h0000);
        check("R9", "ptr_new reset", ptr_new, 16'h0000);
        check("R9", "flags reset", {14'd0, ea_valid, ptr_wr}, 16'd0);
        rst_n = 1'b1;

        // directed cases
        run_op(16'h0105, 8'h87, 8'h00, 1'b0, 1'b0, "R2");   // expect 0x008C
        check("R2", "0x105-121", ea, 16'h008C);
        run_op(16'h0005, 8'hF0, 8'h00, 1'b0, 1'b0, "R2");   // bottom of page 0
        check("R2", "wrap low", ea, 16'h0FF5);
        run_op(16'h3FFE, 8'h05, 8'h00, 1'b1, 1'b0, "R1");   // top of page 3
        check("R1", "wrap high", ea, 16'h3003);
        run_op(16'h2010, 8'h80, 8'h10, 1'b0, 1'b0, "R3");
        check("R3", "ext step", ea, 16'h2020);
        run_op(16'h2010, 8'h80, 8'h10, 1'b1, 1'b1, "R4");
        check("R4", "jump -128", ea, 16'h2F90);
        run_op(16'h4002, 8'h80, 8'hFC, 1'b0, 1'b1, "R5");
        check("R5", "pre-dec via ext", ptr_new, 16'h4FFE);
        run_op(16'h4FFE, 8'h03, 8'h00, 1'b0, 1'b1, "R6");
        check("R6", "post-inc ea", ea, 16'h4FFE);
        check("R6", "post-inc ptr", ptr_new, 16'h4001);

        // idle cycle: outputs hold, valid drops
        hold_ea = ea; hold_ptr = ptr_new;
        valid_in = 1'b0; base = 16'hAAAA; disp = 8'h11;
        @(posedge clk);
        #1;
        check("R8", "valid low", {15'd0, ea_valid}, 16'd0);
        check("R8", "ea held", ea, hold_ea);
        check("R8", "ptr held", ptr_new, hold_ptr);

        // sweep
        foreach (bases[bi])
            foreach (exts[xi])
                for (int d = 0; d < 256; d++)
                    for (int m = 0; m < 4; m++)
                        run_op(bases[bi], 8'(d), exts[xi], m[1], m[0],
                               m[1] ? "R4" : (m[0] ? "R5" : "R2"));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule